// File: doc/BRIEF.md
# Half-Gate Partitioned Column Decoder

This block drives the column side of a memristive crossbar whose `N` bitlines are cut into `K` equal partitions by `K-1` separator transistors. A single wide control word describes one crossbar cycle. For every partition the word holds three local column indices and a three-bit half-gate opcode. It also holds one select bit per separator. The block turns that word into three bitline enable vectors: first-input voltage, second-input voltage and output voltage. It also drives the separator control vector.

Each partition owns a small decoder whose three units are switched on and off by its opcode. A partition may therefore drive only the input half of a gate, only the output half, or nothing at all. Together with the separators, this lets one gate take its inputs in one partition and write its result in another. Setting all separators conducting gives one gate per cycle across the whole row (serial). Setting them all isolating gives one gate per partition (parallel). Mixed settings give semi-parallel sections.

A word is taken when `ctrl_valid` is high at a rising clock edge. The decoded enables appear after that edge and hold until the next accepted word.

Top module: `halfgate_col_decoder`

## Requirements
- R1: While `rst_n` is low at a rising edge, all three enable vectors become all-zero and every bit of `sep_conduct` becomes 1 (conducting). This holds even if `ctrl_valid` is high during reset.
- R2: A word presented with `ctrl_valid` high at a rising edge is reflected on every output right after that edge. With `ctrl_valid` low, the outputs keep their values, whatever `ctrl_word` carries.
- R3: Index field layout: with `L = log2(N/K)`, partition `p` takes its first-input index from bits `[3pL +: L]`, its second-input index from `[3pL+L +: L]` and its output index from `[3pL+2L +: L]`.
- R4: Partition `p`'s opcode sits at bits `[3KL+3p +: 3]`. Bit 2 enables the first-input unit, bit 1 the second-input unit and bit 0 the output unit. A disabled unit drives all-zero on that partition's slice of its vector.
- R5: An enabled unit of partition `p` with local index `i` sets exactly bit `p*(N/K)+i` of its vector.
- R6: Within each partition slice of `N/K` bits, each enable vector has at most one bit set.
- R7: Separator `j`, which lies between partitions `j` and `j+1`, takes bit `[3KL+3K+j]` of the word. A value of 1 means conducting and 0 means isolating.
- R8: Half gates. Opcode 110 drives only the two input enables of its partition. Opcode 001 drives only the output enable. Opcode 000 drives nothing, which is used for partitions lying between a gate's input and output partitions.
- R9: Each partition decodes its own fields only. Its enables do not depend on the separators or on other partitions, so all-isolating separators with opcode 111 everywhere yield `K` complete gates at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_valid | input | 1 | Accept strobe for `ctrl_word` |
| ctrl_word | input | 3K·log2(N/K)+3K+K-1 | Packed indices, opcodes and separator selects |
| en_in_a | output | N | One-hot-per-partition first-input bitline enables |
| en_in_b | output | N | One-hot-per-partition second-input bitline enables |
| en_out | output | N | One-hot-per-partition output bitline enables |
| sep_conduct | output | K-1 | Separator transistor controls, 1 = conducting |

## Verification
Every output sits one register stage behind the input. The result of a word accepted at edge t is therefore due just after edge t. The bench drives on the falling edge and reads back on the following falling edge, half a cycle after the capture. Hold behaviour is checked one full cycle later, after a different word has been driven with the strobe low. The reset state is read on the falling edge after a reset edge, and the expected vectors come from bench functions that pack and decode the word fields on their own.

// File: rtl/hgd_pkg.sv
// Package: shared types for the half-gate partitioned column decoder.
// Assumes the opcode order {first input, second input, output}, MSB first.
package hgd_pkg;

    // Number of decoder units per partition (first input, second input, output)
    localparam int UNITS = 3;

    // Half-gate opcode of one partition
    typedef struct packed {
        logic use_a;
        logic use_b;
        logic use_out;
    } hg_op_t;

    // Opcode encodings used by the design and bench
    localparam hg_op_t OP_IDLE     = 3'b000;
    localparam hg_op_t OP_OUT_HALF = 3'b001;
    localparam hg_op_t OP_IN_HALF  = 3'b110;
    localparam hg_op_t OP_FULL     = 3'b111;

endpackage

// File: rtl/hgd_onehot.sv
// Module: hgd_onehot
// Purpose: gated binary-to-one-hot decoder for one decoder unit of a partition.
// Assumes: COLS is 2**IDX_W; output is all-zero when enable is low.
module hgd_onehot #(
    parameter int IDX_W = 3,
    localparam int COLS = 1 << IDX_W
) (
    input  logic             unit_en,
    input  logic [IDX_W-1:0] local_idx,
    output logic [COLS-1:0]  col_hot
);

    // One comparator per column of the partition
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign col_hot[c] = unit_en && (local_idx == IDX_W'(c));
    end

endmodule

// File: rtl/hgd_partition.sv
// Module: hgd_partition
// Purpose: decodes and registers the three bitline enables of one partition.
// Assumes: synchronous active-low reset; load samples the fields on a rising edge.
module hgd_partition
    import hgd_pkg::*;
#(
    parameter int IDX_W = 3,
    localparam int COLS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] idx_a,
    input  logic [IDX_W-1:0] idx_b,
    input  logic [IDX_W-1:0] idx_out,
    input  hg_op_t           opcode,
    output logic [COLS-1:0]  hot_a_q,
    output logic [COLS-1:0]  hot_b_q,
    output logic [COLS-1:0]  hot_out_q
);

    logic [IDX_W-1:0] unit_idx [UNITS];
    logic             unit_en  [UNITS];
    logic [COLS-1:0]  unit_hot [UNITS];

    // Route each index and opcode bit to its decoder unit
    always_comb begin
        unit_idx[0] = idx_a;
        unit_idx[1] = idx_b;
        unit_idx[2] = idx_out;
        unit_en[0]  = opcode.use_a;
        unit_en[1]  = opcode.use_b;
        unit_en[2]  = opcode.use_out;
    end

    // One gated decoder per unit
    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        hgd_onehot #(.IDX_W(IDX_W)) u_dec (
            .unit_en   (unit_en[u]),
            .local_idx (unit_idx[u]),
            .col_hot   (unit_hot[u])
        );
    end

    // Register the decoded enables on an accepted word, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot_a_q   <= '0;
            hot_b_q   <= '0;
            hot_out_q <= '0;
        end else if (load) begin
            hot_a_q   <= unit_hot[0];
            hot_b_q   <= unit_hot[1];
            hot_out_q <= unit_hot[2];
        end
    end

endmodule

// File: rtl/hgd_separators.sv
// Module: hgd_separators
// Purpose: holds the separator transistor controls between partitions.
// Assumes: 1 = conducting; reset makes the whole row one section.
module hgd_separators #(
    parameter int NSEP = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [NSEP-1:0] sel_in,
    output logic [NSEP-1:0] sel_q
);

    // Capture separator selects, all conducting after reset
    always_ff @(posedge clk) begin
        if (!rst_n)    sel_q <= '1;
        else if (load) sel_q <= sel_in;
    end

endmodule

// File: rtl/halfgate_col_decoder.sv
// Module: halfgate_col_decoder (top)
// Purpose: splits the packed control word into per-partition half-gate decoders
//          and separator controls; outputs are registered on ctrl_valid.
// Assumes: N and K are powers of two, K >= 2 and K divides N.
module halfgate_col_decoder
    import hgd_pkg::*;
#(
    parameter int N = 1024,
    parameter int K = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   ctrl_valid,
    input  logic [3*K*$clog2(N/K)+3*K+K-2:0]       ctrl_word,
    output logic [N-1:0]                           en_in_a,
    output logic [N-1:0]                           en_in_b,
    output logic [N-1:0]                           en_out,
    output logic [K-2:0]                           sep_conduct
);

    localparam int COLS    = N / K;
    localparam int IDX_W   = $clog2(COLS);
    localparam int FIELD_W = UNITS * IDX_W;
    localparam int OPC_LSB = K * FIELD_W;
    localparam int SEL_LSB = OPC_LSB + UNITS * K;

    // One decoder slice per partition
    for (genvar p = 0; p < K; p++) begin : g_part
        hg_op_t part_op;

        // Extract this partition's opcode
        assign part_op = hg_op_t'(ctrl_word[OPC_LSB + UNITS*p +: UNITS]);

        hgd_partition #(.IDX_W(IDX_W)) u_part (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (ctrl_valid),
            .idx_a     (ctrl_word[p*FIELD_W            +: IDX_W]),
            .idx_b     (ctrl_word[p*FIELD_W + IDX_W    +: IDX_W]),
            .idx_out   (ctrl_word[p*FIELD_W + 2*IDX_W  +: IDX_W]),
            .opcode    (part_op),
            .hot_a_q   (en_in_a[p*COLS +: COLS]),
            .hot_b_q   (en_in_b[p*COLS +: COLS]),
            .hot_out_q (en_out [p*COLS +: COLS])
        );
    end

    hgd_separators #(.NSEP(K-1)) u_sep (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ctrl_valid),
        .sel_in (ctrl_word[SEL_LSB +: K-1]),
        .sel_q  (sep_conduct)
    );

endmodule

// File: rtl/hgd_checker.sv
// Module: hgd_checker
// Purpose: temporal checks on the decoder ports, bound to the top module.
module hgd_checker #(
    parameter int N = 1024,
    parameter int K = 32
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             ctrl_valid,
    input logic [3*K*$clog2(N/K)+3*K+K-2:0] ctrl_word,
    input logic [N-1:0]                     en_in_a,
    input logic [N-1:0]                     en_in_b,
    input logic [N-1:0]                     en_out,
    input logic [K-2:0]                     sep_conduct
);

    localparam int COLS    = N / K;
    localparam int IDX_W   = $clog2(COLS);
    localparam int OPC_LSB = K * 3 * IDX_W;
    localparam int SEL_LSB = OPC_LSB + 3 * K;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (en_in_a == '0 && en_in_b == '0 && en_out == '0 && sep_conduct == '1));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_valid |=> ($stable(en_in_a) && $stable(en_in_b) && $stable(en_out) && $stable(sep_conduct)));

    // R7
    sep_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid |=> (sep_conduct == $past(ctrl_word[SEL_LSB +: K-1])));

    for (genvar p = 0; p < K; p++) begin : g_chk
        // R6
        onehot_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(en_in_a[p*COLS +: COLS]) && $onehot0(en_in_b[p*COLS +: COLS])
            && $onehot0(en_out[p*COLS +: COLS]));

        // R4
        out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_valid |=> ($countones(en_out[p*COLS +: COLS]) == 32'($past(ctrl_word[OPC_LSB + 3*p]))));

        // R4
        in_a_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_valid |=> ($countones(en_in_a[p*COLS +: COLS]) == 32'($past(ctrl_word[OPC_LSB + 3*p + 2]))));
    end

endmodule

bind halfgate_col_decoder hgd_checker #(.N(N), .K(K)) u_hgd_checker (.*);

// File: tb/halfgate_col_decoder_test.sv
// Bench: random and directed control words checked against bench-side decode.
module halfgate_col_decoder_test;

    localparam int N     = 64;
    localparam int K     = 8;
    localparam int COLS  = N / K;
    localparam int L     = 3;
    localparam int IDX_W = 3 * K * L;
    localparam int SEL   = IDX_W + 3 * K;
    localparam int W     = SEL + K - 1;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         ctrl_valid = 0;
    logic [W-1:0] ctrl_word = '0;
    logic [N-1:0] en_in_a, en_in_b, en_out;
    logic [K-2:0] sep_conduct;

    int ia [K];
    int ib [K];
    int io [K];
    int op [K];
    int sel [K-1];

    int n_checks = 0;
    int n_fail   = 0;

    halfgate_col_decoder #(.N(N), .K(K)) uut (
        .clk, .rst_n, .ctrl_valid, .ctrl_word, .en_in_a, .en_in_b, .en_out, .sep_conduct
    );

    always #4 clk = ~clk;

    // Pack bench fields into a control word (R3, R4, R7 layouts)
    function automatic logic [W-1:0] pack_word();
        logic [W-1:0] w = '0;
        for (int p = 0; p < K; p++) begin
            w[p*3*L +: L]       = ia[p][L-1:0];
            w[p*3*L + L +: L]   = ib[p][L-1:0];
            w[p*3*L + 2*L +: L] = io[p][L-1:0];
            w[IDX_W + 3*p +: 3] = op[p][2:0];
        end
        for (int j = 0; j < K-1; j++) w[SEL + j] = sel[j][0];
        return w;
    endfunction

    // Expected enable vector for unit u (0 first input, 1 second input, 2 output), R5
    function automatic logic [N-1:0] exp_vec(int u);
        logic [N-1:0] v = '0;
        for (int p = 0; p < K; p++) begin
            int idx = (u == 0) ? ia[p] : (u == 1) ? ib[p] : io[p];
            if (op[p][2-u]) v[p*COLS + idx] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [K-2:0] exp_sep();
        logic [K-2:0] s;
        for (int j = 0; j < K-1; j++) s[j] = sel[j][0];
        return s;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " in_a"}, en_in_a, exp_vec(0));
        check({req, " in_b"}, en_in_b, exp_vec(1));
        check({req, " out"},  en_out,  exp_vec(2));
        check({req, " sep"},  N'(sep_conduct), N'(exp_sep()));
    endtask

    task automatic randomize_fields();
        for (int p = 0; p < K; p++) begin
            ia[p] = $urandom_range(COLS-1);
            ib[p] = $urandom_range(COLS-1);
            io[p] = $urandom_range(COLS-1);
            op[p] = $urandom_range(7);
        end
        for (int j = 0; j < K-1; j++) sel[j] = $urandom_range(1);
    endtask

    // Drive at falling edge, capture on the next rising edge, read at the falling edge after
    task automatic apply_word();
        @(negedge clk);
        ctrl_word  = pack_word();
        ctrl_valid = 1'b1;
        @(negedge clk);
        ctrl_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1: reset with a strobed word present
        randomize_fields();
        ctrl_word  = pack_word();
        ctrl_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 in_a", en_in_a, '0);
        check("R1 in_b", en_in_b, '0);
        check("R1 out",  en_out,  '0);
        check("R1 sep",  N'(sep_conduct), N'({(K-1){1'b1}}));
        ctrl_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R8: serial gate, inputs in partition 1, output in partition 4, middle idle
        for (int p = 0; p < K; p++) begin ia[p] = 2; ib[p] = 5; io[p] = 7; op[p] = 0; end
        for (int j = 0; j < K-1; j++) sel[j] = 1;
        op[1] = 6; op[4] = 1;
        apply_word();
        check_all("R8 serial half gates");

        // R9: fully parallel, every partition a complete gate
        for (int p = 0; p < K; p++) begin ia[p] = p; ib[p] = COLS-1-p; io[p] = (p+3)%COLS; op[p] = 7; end
        for (int j = 0; j < K-1; j++) sel[j] = 0;
        apply_word();
        check_all("R9 parallel");

        // R5: boundary indices, column 0 and column N-1
        for (int p = 0; p < K; p++) begin ia[p] = 0; ib[p] = 0; io[p] = COLS-1; op[p] = 0; end
        op[0] = 7; op[K-1] = 7;
        for (int j = 0; j < K-1; j++) sel[j] = j % 2;
        apply_word();
        check_all("R5 edge columns");

        // R2: hold while another word is driven with the strobe low
        begin
            logic [W-1:0] keep = ctrl_word;
            ctrl_word = ~keep;
            @(negedge clk);
            check_all("R2 hold");
        end

        // R3 R4 R6 R7: constrained random words, with hold checks in between
        for (int t = 0; t < 60; t++) begin
            randomize_fields();
            apply_word();
            check_all("R3 R4 R6 R7 random");
            ctrl_word = {W{1'b1}} ^ ctrl_word;
            @(negedge clk);
            check_all("R2 random hold");
        end

        // R1: reset in mid-run clears a loaded state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid in_a", en_in_a, '0);
        check("R1 mid out",  en_out,  '0);
        check("R1 mid sep",  N'(sep_conduct), N'({(K-1){1'b1}}));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule